// File: doc/BRIEF.md
# Dual-Port Reshapable RAM with Collision Priority

This block holds 4096 bits of storage that two independent ports, A and B, can reach in the same clock cycle. A static organization input sets the word shape: 4096 words of 1 bit, 2048 of 2, 1024 of 4, or 512 of 8. All shapes share one physical array of 512 rows, each 8 bits wide. In the narrow shapes, the low address bits pick a lane inside a row.

Both ports are synchronous. A read returns the word as it was before any write in the same edge. When both enabled ports name the same effective address, the block drives an active-low match flag. It then resolves the access by a fixed priority that depends on the pair of operations. A static lock input turns the array into a ROM or lookup table: every write is dropped, and the contents stay as the power-up image given by a parameter. Port A's data output is registered once by default. Port B can add a second output register, which is on by default.

Each port is a plain request strobe with no back-pressure. An enabled request is always accepted in the cycle it is presented, so the block has no ready pin. A requester must not expect a request to be held or retried.

Top module: `chanram_dp`

## Requirements
- R1: `org` = 0, 1, 2, 3 selects a word width W of 1, 2, 4 or 8 bits. The effective address is the address with every bit at or above position 12-`org` cleared. Row = effective address >> (3-`org`). Lane k = the low (3-`org`) bits of the effective address, and it occupies row bits [k*W +: W]. Data-in bits at or above W are ignored. Data-out bits at or above W read 0.
- R2: A port's read data appears on `a_rdata` one clock after the enabled edge, and on `b_rdata` two clocks after it (default output registers). The output holds while the port is disabled. Reset clears both outputs to 0.
- R3: A read and a write on the same port in the same cycle (`x_en`=1, `x_we`=1) return the word that was stored before the write.
- R4: `match_n` is combinational. It is 0 exactly when both ports are enabled and their effective addresses are equal, and 1 otherwise.
- R5: When both ports read the same address, both return the stored word.
- R6: When A writes and B reads the same address, A's write takes effect. B returns the old word, and a later read by B returns the new word.
- R7: When B writes and A reads the same address, B's write takes effect. A returns the old word, and a later read by A returns the new word.
- R8: When both ports write the same address, A's data is stored and B's write is discarded.
- R9: While `wr_lock`=1, write requests on both ports leave the array unchanged.
- R10: After power-up, row r holds (r*7+3) mod 256 under the default image parameter.
- R11: Writes from both ports to different lanes of the same physical row in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears read outputs |
| org | input | 2 | Word organization select (static) |
| wr_lock | input | 1 | ROM/LUT lock, blocks all writes |
| a_en | input | 1 | Port A request strobe |
| a_we | input | 1 | Port A write (with a_en) |
| a_addr | input | 12 | Port A address |
| a_wdata | input | 8 | Port A write data, low W bits used |
| a_rdata | output | 8 | Port A read data |
| b_en | input | 1 | Port B request strobe |
| b_we | input | 1 | Port B write (with b_en) |
| b_addr | input | 12 | Port B address |
| b_wdata | input | 8 | Port B write data, low W bits used |
| b_rdata | output | 8 | Port B read data |
| match_n | output | 1 | Active-low same-address flag |

## Verification
A write on one port and a read on the other can hit the same effective address in the same cycle. In that case, collision arbitration and the read-before-write return both act on one edge. The bench provokes this with vectors that give both ports equal addresses, in every shape and including addresses that differ only in ignored upper bits. It samples `match_n` before the edge and both outputs after their latencies. It judges the results against a reference model of the array that applies A's write, then B's write only if B is not blocked. A follow-up read on the losing port must then show the new word.

// File: rtl/chanram_pkg.sv
package chanram_pkg;
  localparam int unsigned TOTAL_BITS = 4096;
  localparam int unsigned PHYS_W     = 8;
  localparam int unsigned ROWS       = TOTAL_BITS / PHYS_W;

  typedef enum logic [1:0] {
    ORG_X1 = 2'd0,
    ORG_X2 = 2'd1,
    ORG_X4 = 2'd2,
    ORG_X8 = 2'd3
  } org_e;

  // power-up image: row r holds (r*7+3) mod 256
  function automatic logic [TOTAL_BITS-1:0] default_image();
    logic [TOTAL_BITS-1:0] img;
    img = '0;
    for (int r = 0; r < int'(ROWS); r++)
      img[r*PHYS_W +: PHYS_W] = PHYS_W'(r * 7 + 3);
    return img;
  endfunction
endpackage

// File: rtl/chanram_addr_map.sv
// Maps a port address and organization onto a physical row, lane offset and mask.
module chanram_addr_map #(
  parameter int unsigned PHYS_W = 8,
  parameter int unsigned ROWS   = 512
) (
  org_i,
  addr_i,
  eff_o,
  row_o,
  shift_o,
  lmask_o
);
  localparam int unsigned LB  = $clog2(PHYS_W);
  localparam int unsigned RAW = $clog2(ROWS);
  localparam int unsigned AW  = RAW + LB;
  localparam int unsigned OW  = $clog2(LB + 1);

  input  logic [OW-1:0]     org_i;
  input  logic [AW-1:0]     addr_i;
  output logic [AW-1:0]     eff_o;
  output logic [RAW-1:0]    row_o;
  output logic [LB-1:0]     shift_o;
  output logic [PHYS_W-1:0] lmask_o;

  always_comb begin
    int unsigned ord;
    int unsigned sub;
    int unsigned lane;
    logic [AW:0] keep;
    ord = 32'(org_i);
    if (ord > LB) ord = LB;
    sub  = LB - ord;
    keep = ((AW+1)'(1) << (RAW + sub)) - (AW+1)'(1);
    eff_o   = addr_i & keep[AW-1:0];
    row_o   = RAW'(eff_o >> sub);
    lane    = 32'(eff_o) & ((32'd1 << sub) - 32'd1);
    shift_o = LB'(lane << ord);
    lmask_o = PHYS_W'(((32'd1 << (32'd1 << ord)) - 32'd1) << (lane << ord));
  end
endmodule

// File: rtl/chanram_arbiter.sv
// Same-address detection and write priority between the two ports.
module chanram_arbiter #(
  parameter int unsigned AW = 12
) (
  input  logic          en_a,
  input  logic          we_a,
  input  logic [AW-1:0] eff_a,
  input  logic          en_b,
  input  logic          we_b,
  input  logic [AW-1:0] eff_b,
  input  logic          lock,
  output logic          match_n,
  output logic          wact_a,
  output logic          wact_b
);
  logic same;

  always_comb begin
    same    = en_a && en_b && (eff_a == eff_b);
    match_n = !same;
    wact_a  = en_a && we_a && !lock;
    // port A wins a write/write collision
    wact_b  = en_b && we_b && !lock && !(same && wact_a);
  end
endmodule

// File: rtl/chanram_dp.sv
module chanram_dp #(
  parameter int unsigned PHYS_W    = chanram_pkg::PHYS_W,
  parameter int unsigned ROWS      = chanram_pkg::ROWS,
  parameter bit          OUT_REG_A = 1'b0,
  parameter bit          OUT_REG_B = 1'b1,
  parameter logic [ROWS*PHYS_W-1:0] INIT_IMAGE = chanram_pkg::default_image(),
  localparam int unsigned LB  = $clog2(PHYS_W),
  localparam int unsigned RAW = $clog2(ROWS),
  localparam int unsigned AW  = RAW + LB,
  localparam int unsigned OW  = $clog2(LB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OW-1:0]     org,
  input  logic              wr_lock,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [PHYS_W-1:0] a_wdata,
  output logic [PHYS_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [PHYS_W-1:0] b_wdata,
  output logic [PHYS_W-1:0] b_rdata,
  output logic              match_n
);
  localparam int unsigned NP = 2;
  localparam logic [NP-1:0] OREG = {OUT_REG_B, OUT_REG_A};

  logic [PHYS_W-1:0] mem [ROWS];

  logic [AW-1:0]     addr  [NP];
  logic [PHYS_W-1:0] wdata [NP];
  logic [NP-1:0]     en;
  logic [AW-1:0]     eff   [NP];
  logic [RAW-1:0]    row   [NP];
  logic [LB-1:0]     shift [NP];
  logic [PHYS_W-1:0] lmask [NP];
  logic [PHYS_W-1:0] wd_sh [NP];
  logic [PHYS_W-1:0] nxt   [NP];
  logic [PHYS_W-1:0] raw_q [NP];
  logic [PHYS_W-1:0] out_d [NP];
  logic [NP-1:0]     wact;
  logic              rows_eq;
  logic [PHYS_W-1:0] merged;

  initial begin
    for (int i = 0; i < int'(ROWS); i++)
      mem[i] = INIT_IMAGE[i*PHYS_W +: PHYS_W];
  end

  assign addr[0]  = a_addr;
  assign addr[1]  = b_addr;
  assign wdata[0] = a_wdata;
  assign wdata[1] = b_wdata;
  assign en       = {b_en, a_en};

  for (genvar p = 0; p < NP; p++) begin : g_port
    chanram_addr_map #(.PHYS_W(PHYS_W), .ROWS(ROWS)) u_map (
      .org_i   (org),
      .addr_i  (addr[p]),
      .eff_o   (eff[p]),
      .row_o   (row[p]),
      .shift_o (shift[p]),
      .lmask_o (lmask[p])
    );

    always_comb begin
      wd_sh[p] = wdata[p] << shift[p];
      nxt[p]   = (mem[row[p]] & ~lmask[p]) | (wd_sh[p] & lmask[p]);
    end

    // synchronous read, old data on same-edge write
    always_ff @(posedge clk) begin
      if (rst)        raw_q[p] <= '0;
      else if (en[p]) raw_q[p] <= (mem[row[p]] & lmask[p]) >> shift[p];
    end

    if (OREG[p]) begin : g_oreg
      logic [PHYS_W-1:0] oq;
      always_ff @(posedge clk) begin
        if (rst) oq <= '0;
        else     oq <= raw_q[p];
      end
      assign out_d[p] = oq;
    end else begin : g_ocomb
      assign out_d[p] = raw_q[p];
    end
  end

  chanram_arbiter #(.AW(AW)) u_arb (
    .en_a    (a_en),
    .we_a    (a_we),
    .eff_a   (eff[0]),
    .en_b    (b_en),
    .we_b    (b_we),
    .eff_b   (eff[1]),
    .lock    (wr_lock),
    .match_n (match_n),
    .wact_a  (wact[0]),
    .wact_b  (wact[1])
  );

  // both ports writing different lanes of one row: fold into one update
  always_comb begin
    rows_eq = wact[0] && wact[1] && (row[0] == row[1]);
    merged  = (nxt[0] & ~lmask[1]) | (wd_sh[1] & lmask[1]);
  end

  always_ff @(posedge clk) begin
    if (wact[0]) mem[row[0]] <= rows_eq ? merged : nxt[0];
    if (wact[1] && !rows_eq) mem[row[1]] <= nxt[1];
  end

  assign a_rdata = out_d[0];
  assign b_rdata = out_d[1];
endmodule

// File: rtl/chanram_dp_chk.sv
module chanram_dp_chk #(
  parameter int unsigned PHYS_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_lock,
  input logic              a_en,
  input logic              a_we,
  input logic              b_en,
  input logic              b_we,
  input logic              match_n,
  input logic [PHYS_W-1:0] a_rdata,
  input logic [PHYS_W-1:0] b_rdata,
  input logic [PHYS_W-1:0] raw_a,
  input logic              wact_a,
  input logic              wact_b
);
  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (a_rdata == '0 && b_rdata == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !a_en |=> $stable(raw_a));

  // R4
  no_match_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_en || !b_en) |-> match_n);

  // R8
  b_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (!match_n && a_we && b_we) |-> !wact_b);

  // R6
  a_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!match_n && a_we && !wr_lock) |-> wact_a);

  // R9
  lock_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lock |-> (!wact_a && !wact_b));
endmodule

bind chanram_dp chanram_dp_chk #(.PHYS_W(PHYS_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_lock (wr_lock),
  .a_en    (a_en),
  .a_we    (a_we),
  .b_en    (b_en),
  .b_we    (b_we),
  .match_n (match_n),
  .a_rdata (a_rdata),
  .b_rdata (b_rdata),
  .raw_a   (raw_q[0]),
  .wact_a  (wact[0]),
  .wact_b  (wact[1])
);

// File: tb/chanram_dp_tb.sv
`timescale 1ns/1ps
module chanram_dp_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] org = 2'd3;
  logic       wr_lock = 1'b0;
  logic       a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [11:0] a_addr = '0, b_addr = '0;
  logic [7:0]  a_wdata = '0, b_wdata = '0;
  logic [7:0]  a_rdata, b_rdata;
  logic        match_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] model [512];
  logic [7:0] exp_a = '0, exp_b = '0;

  always #4 clk = ~clk;

  chanram_dp u_dut (
    .clk(clk), .rst(rst), .org(org), .wr_lock(wr_lock),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .match_n(match_n)
  );

  typedef struct packed {
    logic [1:0]  o;
    logic        lk;
    logic        ae, aw;
    logic [11:0] aa;
    logic [7:0]  ad;
    logic        be, bw;
    logic [11:0] ba;
    logic [7:0]  bd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h005, 8'h00, 1'b1, 1'b0, 12'h005, 8'h00}, // R5 R10
    '{2'd3, 1'b0, 1'b1, 1'b1, 12'h010, 8'hC3, 1'b1, 1'b0, 12'h010, 8'h00}, // R6 R3
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h011, 8'h00, 1'b1, 1'b0, 12'h010, 8'h00}, // R6 new word
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h020, 8'h00, 1'b1, 1'b1, 12'h020, 8'h99}, // R7
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h020, 8'h00, 1'b0, 1'b0, 12'h000, 8'h00}, // R7 new, R2 hold
    '{2'd3, 1'b0, 1'b1, 1'b1, 12'h030, 8'h11, 1'b1, 1'b1, 12'h030, 8'h22}, // R8
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h030, 8'h00, 1'b1, 1'b0, 12'h030, 8'h00}, // R8 read back
    '{2'd3, 1'b1, 1'b1, 1'b1, 12'h040, 8'hFF, 1'b1, 1'b1, 12'h041, 8'hEE}, // R9
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h040, 8'h00, 1'b1, 1'b0, 12'h041, 8'h00}, // R9 read back
    '{2'd0, 1'b0, 1'b1, 1'b1, 12'h282, 8'h01, 1'b1, 1'b1, 12'h286, 8'hFF}, // R11 R1
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h050, 8'h00, 1'b1, 1'b0, 12'h050, 8'h00}, // R11 read back
    '{2'd1, 1'b0, 1'b1, 1'b0, 12'h941, 8'h00, 1'b1, 1'b0, 12'h141, 8'h00}, // R1 upper bits ignored, R4
    '{2'd2, 1'b0, 1'b1, 1'b1, 12'h0C1, 8'hF5, 1'b1, 1'b0, 12'h0C0, 8'h00}, // R1 data masking
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h060, 8'h00, 1'b0, 1'b0, 12'h000, 8'h00}, // R1 read back
    '{2'd0, 1'b0, 1'b0, 1'b1, 12'h000, 8'hFF, 1'b0, 1'b1, 12'h000, 8'hFF}, // R2 both idle
    '{2'd2, 1'b0, 1'b1, 1'b1, 12'h0C1, 8'h0B, 1'b1, 1'b1, 12'h0C1, 8'h07}, // R8 narrow
    '{2'd3, 1'b0, 1'b1, 1'b0, 12'h060, 8'h00, 1'b1, 1'b0, 12'h060, 8'h00}  // R8 read back
  };

  function automatic int eff_of(logic [1:0] o, logic [11:0] ad);
    return int'(ad) % (1 << (12 - int'(o)));
  endfunction

  function automatic logic [7:0] mrd(logic [1:0] o, logic [11:0] ad);
    int nl = 3 - int'(o);
    int ea = eff_of(o, ad);
    int w  = 1 << int'(o);
    int ln = ea % (1 << nl);
    return 8'((int'(model[ea >> nl]) >> (ln * w)) & ((1 << w) - 1));
  endfunction

  task automatic mwr(logic [1:0] o, logic [11:0] ad, logic [7:0] d);
    int nl = 3 - int'(o);
    int ea = eff_of(o, ad);
    int w  = 1 << int'(o);
    int ln = ea % (1 << nl);
    int m  = ((1 << w) - 1) << (ln * w);
    model[ea >> nl] = 8'((int'(model[ea >> nl]) & ~m) | ((int'(d) << (ln * w)) & m));
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    a_en = 0; a_we = 0; b_en = 0; b_we = 0;
  endtask

  task automatic run_vec(vec_t v, int idx);
    bit same;
    @(negedge clk);
    org = v.o; wr_lock = v.lk;
    a_en = v.ae; a_we = v.aw; a_addr = v.aa; a_wdata = v.ad;
    b_en = v.be; b_we = v.bw; b_addr = v.ba; b_wdata = v.bd;
    same = v.ae && v.be && (eff_of(v.o, v.aa) == eff_of(v.o, v.ba));
    #1;
    check($sformatf("R4 match_n vec %0d", idx), {7'd0, match_n}, {7'd0, !same});
    if (v.ae) exp_a = mrd(v.o, v.aa);
    if (v.be) exp_b = mrd(v.o, v.ba);
    if (!v.lk && v.ae && v.aw) mwr(v.o, v.aa, v.ad);
    if (!v.lk && v.be && v.bw && !(same && v.aw)) mwr(v.o, v.ba, v.bd);
    @(posedge clk);
    @(negedge clk);
    go_idle();
    @(posedge clk);
    @(negedge clk);
    #1;
    check($sformatf("R1/R2 port A vec %0d", idx), a_rdata, exp_a);
    check($sformatf("R1/R2 port B vec %0d", idx), b_rdata, exp_b);
  endtask

  initial begin
    for (int r = 0; r < 512; r++) model[r] = 8'(r * 7 + 3); // R10 image
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R2 reset state
    check("R2 reset a_rdata", a_rdata, 8'h00);
    check("R2 reset b_rdata", b_rdata, 8'h00);
    check("R4 idle match_n", {7'd0, match_n}, 8'h01);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R2 latency: A after one edge, B only after two
    @(negedge clk);
    org = 2'd3; wr_lock = 0;
    a_en = 1; a_addr = 12'h005; b_en = 1; b_addr = 12'h007;
    @(posedge clk);
    @(negedge clk);
    go_idle();
    #1;
    check("R2 A one-cycle latency", a_rdata, model[5]);
    check("R2 B not yet updated", b_rdata, exp_b);
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R2 B two-cycle latency", b_rdata, model[7]);

    // R3 same-port read during write, then new word
    @(negedge clk);
    a_en = 1; a_we = 1; a_addr = 12'h100; a_wdata = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    go_idle();
    #1;
    check("R3 old word on write", a_rdata, model[256]);
    model[256] = 8'h3C;
    a_en = 1; a_addr = 12'h100;
    @(posedge clk);
    @(negedge clk);
    go_idle();
    #1;
    check("R3 new word after write", a_rdata, 8'h3C);

    // R2 reset clears outputs after activity
    rst = 1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R2 reset clears A", a_rdata, 8'h00);
    check("R2 reset clears B", b_rdata, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule